// File: doc/BRIEF.md
# Low-Pin VGA Raster Timing Generator

This block turns one fast system clock into the complete raster timing for a VGA-style display that has very few output pins. Every scanline has a fixed length in clocks. The block drives a single active-low composite sync. During vertical sync lines that sync takes the opposite polarity. The block also gives a pixel strobe that paces a reduced horizontal resolution, and a pixel index for each strobe. It outputs a logical row index, in which each row covers two physical lines, and single-cycle pulses at the start of each line and each frame.

The 3-bit colour from the pixel source passes through only inside the active window, and only while sync is high. In every other cycle it is forced to black. A 1-bit square-wave tone shares the sync interval. The tone level changes at line start, inside the horizontal sync pulse, and it toggles after a programmable number of lines. The tone is driven only while horizontal sync is low on lines that carry a normal sync pulse, and it is silent on the vertical sync lines.

At its defaults the block uses 1146 clocks per line at 36 MHz. It has 920 active clocks with a strobe every 5 clocks, which gives 184 pixels. It has 480 drawn lines in a 525-line frame, which gives roughly 60 Hz.

Top module: `vga_raster_gen`

## Requirements
- R1: `line_start` is high for exactly one clock every LINE_CLKS clocks. It is high in the first clock after reset and repeats every LINE_CLKS clocks after that.
- R2: A frame is LINES_TOTAL lines long. `frame_start` is high only in the first clock of line 0, and `line_idx` gives the current physical line, counting from 0.
- R3: On drawn lines (line < LINES_VIS), `pix_stb` is high in clock ACT_START + k*PIX_DIV of the line, for k = 0 .. ACT_CLKS/PIX_DIV-1. In that clock `pix_x` equals k. Outside those clocks `pix_stb` is 0 and `pix_x` is 0.
- R4: `row` equals line/2 on drawn lines and 0 on every other line.
- R5: On lines outside vertical sync, `csync_n` is 0 for the first HSYNC_CLKS clocks of the line and 1 for the rest of the line.
- R6: On the VSYNC_LINES lines that start at line VSYNC_START, the polarity of `csync_n` is inverted. It is 1 for the first HSYNC_CLKS clocks and 0 for the rest of the line.
- R7: `in_sync` is 1 exactly when `csync_n` is 0.
- R8: `rgb_out` equals `rgb_in` inside the active window of a drawn line (line clocks ACT_START .. ACT_START+ACT_CLKS-1) while `csync_n` is 1. In every other cycle it is 3'b000.
- R9: The tone level toggles at the start of a line after every `tone_period` counted lines. Only lines outside vertical sync are counted. A `tone_period` of 0 clears the level and the count.
- R10: `tone_out` carries the tone level only during the first HSYNC_CLKS clocks of lines outside vertical sync, and is 0 at all other times. The level changes only when line clock 0 ends.
- R11: While `rst_n` is low at a clock edge, the block returns to line 0, line clock 0, with the tone level 0 and the tone count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rgb_in | input | 3 | Pixel colour from the pixel source (bit 2 red, bit 1 green, bit 0 blue) |
| tone_period | input | TONE_W | Number of counted lines per tone toggle, 0 for silence |
| csync_n | output | 1 | Composite sync, active low |
| in_sync | output | 1 | High while composite sync is low |
| rgb_out | output | 3 | Colour after blanking |
| pix_stb | output | 1 | Pixel strobe |
| pix_x | output | clog2(ACT_CLKS/PIX_DIV+1) | Pixel index for the current strobe |
| row | output | clog2(LINES_VIS/2) | Logical row index |
| line_idx | output | clog2(LINES_TOTAL) | Physical line index |
| line_start | output | 1 | One-clock pulse at the start of each line |
| frame_start | output | 1 | One-clock pulse at the start of each frame |
| tone_out | output | 1 | Square-wave tone, driven only inside horizontal sync |

## Verification
The bench runs a shortened raster through several whole frames. The colour input changes every clock from an LFSR pattern, which separates a correct blanking mask from a window that is shifted by one clock or left open during sync. The tone period is stepped through 3, 1, 0 and 2 over the run. This tells apart counting every line from counting only lines that carry a sync pulse, and it shows that period 0 forces silence. Because every frame crosses the vertical sync lines, the bench sees the sync polarity flip and the tone drop to zero there. The odd/even line pairs show whether rows are halved correctly.

// File: rtl/vga_raster_pkg.sv
// Package: shared types for the raster generator.
// Assumes colour is one bit each for red, green and blue.
package vga_raster_pkg;
    typedef logic [2:0] rgb_t;
    localparam rgb_t RGB_BLACK = 3'b000;
endpackage

// File: rtl/vga_line_timer.sv
// Module: horizontal timing. Counts the clocks of one line and paces pixels
// inside the active window.
// Assumes ACT_START >= 1, HSYNC_CLKS < ACT_START and ACT_START+ACT_CLKS <= LINE_CLKS.
module vga_line_timer #(
    parameter int LINE_CLKS  = 1146,
    parameter int HSYNC_CLKS = 129,
    parameter int ACT_START  = 200,
    parameter int ACT_CLKS   = 920,
    parameter int PIX_DIV    = 5,
    localparam int HW = $clog2(LINE_CLKS),
    localparam int NPIX = ACT_CLKS / PIX_DIV,
    localparam int XW = $clog2(NPIX + 1),
    localparam int PW = (PIX_DIV > 1) ? $clog2(PIX_DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_cnt,
    output logic          line_end,
    output logic          hsync_win,
    output logic          act_win,
    output logic          pix_phase0,
    output logic [XW-1:0] pix_idx
);
    localparam logic [HW-1:0] H_LAST  = HW'(LINE_CLKS - 1);
    localparam logic [HW-1:0] H_SYNC  = HW'(HSYNC_CLKS);
    localparam logic [HW-1:0] H_PRE   = HW'(ACT_START - 1);
    localparam logic [HW-1:0] H_ACT0  = HW'(ACT_START);
    localparam logic [HW-1:0] H_ACT1  = HW'(ACT_START + ACT_CLKS);
    localparam logic [PW-1:0] P_LAST  = PW'(PIX_DIV - 1);

    logic [PW-1:0] phase;

    assign line_end   = (h_cnt == H_LAST);
    assign hsync_win  = (h_cnt < H_SYNC);
    assign act_win    = (h_cnt >= H_ACT0) && (h_cnt < H_ACT1);
    assign pix_phase0 = (phase == '0);

    // Line clock counter, wrapping at the end of each line.
    always_ff @(posedge clk) begin
        if (!rst_n)        h_cnt <= '0;
        else if (line_end) h_cnt <= '0;
        else               h_cnt <= h_cnt + 1'b1;
    end

    // Pixel phase and index, aligned to the first active clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= '0;
            pix_idx <= '0;
        end else if (h_cnt == H_PRE) begin
            phase   <= '0;
            pix_idx <= '0;
        end else if (act_win) begin
            if (phase == P_LAST) begin
                phase   <= '0;
                pix_idx <= pix_idx + 1'b1;
            end else begin
                phase   <= phase + 1'b1;
            end
        end
    end

    p_hwrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt == H_LAST) |=> (h_cnt == '0));
    p_pix_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_win |-> (pix_idx < XW'(NPIX)));
endmodule

// File: rtl/vga_frame_timer.sv
// Module: vertical timing. Counts lines within a frame and derives the
// drawn-line, vertical-sync-line and logical-row information.
// Assumes LINES_VIS is even and the vertical sync lines lie after the drawn lines.
module vga_frame_timer #(
    parameter int LINES_VIS   = 480,
    parameter int LINES_TOTAL = 525,
    parameter int VSYNC_START = 490,
    parameter int VSYNC_LINES = 2,
    localparam int VW = $clog2(LINES_TOTAL),
    localparam int RW = $clog2(LINES_VIS / 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    output logic [VW-1:0] v_cnt,
    output logic          vis_line,
    output logic          vsync_line,
    output logic [RW-1:0] row
);
    localparam logic [VW-1:0] V_LAST = VW'(LINES_TOTAL - 1);
    localparam logic [VW-1:0] V_VIS  = VW'(LINES_VIS);
    localparam logic [VW-1:0] V_VS0  = VW'(VSYNC_START);
    localparam logic [VW-1:0] V_VS1  = VW'(VSYNC_START + VSYNC_LINES);

    logic [VW-1:0] half;

    assign vis_line   = (v_cnt < V_VIS);
    assign vsync_line = (v_cnt >= V_VS0) && (v_cnt < V_VS1);
    assign half       = v_cnt >> 1;
    assign row        = vis_line ? half[RW-1:0] : '0;

    // Line counter, advanced at each line end and wrapping at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)                          v_cnt <= '0;
        else if (line_end && v_cnt == V_LAST) v_cnt <= '0;
        else if (line_end)                   v_cnt <= v_cnt + 1'b1;
    end

    p_vwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && v_cnt == V_LAST) |=> (v_cnt == '0));
    p_vhold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(v_cnt));
endmodule

// File: rtl/vga_tone_gen.sv
// Module: square-wave tone. Counts qualifying lines and toggles its level after
// every tone_period of them. Period 0 clears the level and the count.
// Assumes line_tick pulses in line clock 0, which lies inside the sync pulse.
module vga_tone_gen #(
    parameter int TONE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic [TONE_W-1:0] tone_period,
    output logic              tone_lvl
);
    logic [TONE_W-1:0] lines;
    logic [TONE_W:0]   next_lines;

    assign next_lines = {1'b0, lines} + 1'b1;

    // Line count and level toggle, updated on qualifying line ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines    <= '0;
            tone_lvl <= 1'b0;
        end else if (line_tick) begin
            if (tone_period == '0) begin
                lines    <= '0;
                tone_lvl <= 1'b0;
            end else if (next_lines >= {1'b0, tone_period}) begin
                lines    <= '0;
                tone_lvl <= ~tone_lvl;
            end else begin
                lines    <= next_lines[TONE_W-1:0];
            end
        end
    end

    p_tone_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tone_lvl) |-> $past(line_tick));
endmodule

// File: rtl/vga_raster_gen.sv
// Module: top of the raster generator. Joins the line and frame timers and the
// tone generator, and forms composite sync, blanked colour and the pulses.
// Assumes the defaults describe a 36 MHz clock; smaller values shorten the raster.
module vga_raster_gen #(
    parameter int LINE_CLKS   = 1146,
    parameter int HSYNC_CLKS  = 129,
    parameter int ACT_START   = 200,
    parameter int ACT_CLKS    = 920,
    parameter int PIX_DIV     = 5,
    parameter int LINES_VIS   = 480,
    parameter int LINES_TOTAL = 525,
    parameter int VSYNC_START = 490,
    parameter int VSYNC_LINES = 2,
    parameter int TONE_W      = 8,
    localparam int HW = $clog2(LINE_CLKS),
    localparam int XW = $clog2(ACT_CLKS / PIX_DIV + 1),
    localparam int VW = $clog2(LINES_TOTAL),
    localparam int RW = $clog2(LINES_VIS / 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        rgb_in,
    input  logic [TONE_W-1:0] tone_period,
    output logic              csync_n,
    output logic              in_sync,
    output logic [2:0]        rgb_out,
    output logic              pix_stb,
    output logic [XW-1:0]     pix_x,
    output logic [RW-1:0]     row,
    output logic [VW-1:0]     line_idx,
    output logic              line_start,
    output logic              frame_start,
    output logic              tone_out
);
    import vga_raster_pkg::*;

    logic [HW-1:0] h_cnt;
    logic          line_end, hsync_win, act_win, pix_phase0;
    logic [XW-1:0] pix_idx;
    logic          vis_line, vsync_line, active, tone_lvl;

    vga_line_timer #(
        .LINE_CLKS(LINE_CLKS), .HSYNC_CLKS(HSYNC_CLKS), .ACT_START(ACT_START),
        .ACT_CLKS(ACT_CLKS), .PIX_DIV(PIX_DIV)
    ) u_line (
        .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .line_end(line_end),
        .hsync_win(hsync_win), .act_win(act_win), .pix_phase0(pix_phase0),
        .pix_idx(pix_idx)
    );

    vga_frame_timer #(
        .LINES_VIS(LINES_VIS), .LINES_TOTAL(LINES_TOTAL),
        .VSYNC_START(VSYNC_START), .VSYNC_LINES(VSYNC_LINES)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .v_cnt(line_idx),
        .vis_line(vis_line), .vsync_line(vsync_line), .row(row)
    );

    vga_tone_gen #(.TONE_W(TONE_W)) u_tone (
        .clk(clk), .rst_n(rst_n),
        .line_tick((h_cnt == '0) && !vsync_line),
        .tone_period(tone_period), .tone_lvl(tone_lvl)
    );

    // Output shaping: sync polarity, blanking, strobes and pulses.
    always_comb begin
        active      = act_win && vis_line;
        csync_n     = vsync_line ? hsync_win : !hsync_win;
        in_sync     = !csync_n;
        rgb_out     = (active && csync_n) ? rgb_t'(rgb_in) : RGB_BLACK;
        pix_stb     = active && pix_phase0;
        pix_x       = active ? pix_idx : '0;
        line_start  = (h_cnt == '0);
        frame_start = line_start && (line_idx == '0);
        tone_out    = tone_lvl && hsync_win && !vsync_line;
    end

    p_black_in_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !csync_n |-> (rgb_out == RGB_BLACK));
    p_tone_in_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tone_out |-> !csync_n);
    p_strobe_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |-> (vis_line && csync_n));
    p_frame_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> line_start);
endmodule

// File: tb/test_vga_raster_gen.sv
module test_vga_raster_gen;
    localparam int LC = 40, HS = 6, AS = 12, AC = 20, PD = 5;
    localparam int LV = 8, LT = 12, VS0 = 9, VSN = 2, TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] rgb_in = 3'd0;
    logic [TW-1:0] tone_period = 8'd3;
    logic csync_n, in_sync, pix_stb, line_start, frame_start, tone_out;
    logic [2:0] rgb_out;
    logic [$clog2(AC/PD+1)-1:0] pix_x;
    logic [$clog2(LV/2)-1:0] row;
    logic [$clog2(LT)-1:0] line_idx;

    int checks = 0, failures = 0;
    int hm = 0, vm = 0, tl = 0, tc = 0;
    bit done = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    vga_raster_gen #(
        .LINE_CLKS(LC), .HSYNC_CLKS(HS), .ACT_START(AS), .ACT_CLKS(AC),
        .PIX_DIV(PD), .LINES_VIS(LV), .LINES_TOTAL(LT), .VSYNC_START(VS0),
        .VSYNC_LINES(VSN), .TONE_W(TW)
    ) i_vga_raster_gen (
        .clk(clk), .rst_n(rst_n), .rgb_in(rgb_in), .tone_period(tone_period),
        .csync_n(csync_n), .in_sync(in_sync), .rgb_out(rgb_out),
        .pix_stb(pix_stb), .pix_x(pix_x), .row(row), .line_idx(line_idx),
        .line_start(line_start), .frame_start(frame_start), .tone_out(tone_out)
    );

    always #10 clk = ~clk;

    // Reference model: behavioural raster position and tone state.
    always @(posedge clk) begin
        if (!rst_n) begin
            hm = 0; vm = 0; tl = 0; tc = 0;
        end else begin
            if (hm == 0 && !(vm >= VS0 && vm < VS0 + VSN)) begin
                if (tone_period == 0) begin tl = 0; tc = 0; end
                else if (tc + 1 >= int'(tone_period)) begin tc = 0; tl = 1 - tl; end
                else tc = tc + 1;
            end
            hm = hm + 1;
            if (hm == LC) begin
                hm = 0;
                vm = (vm == LT - 1) ? 0 : vm + 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s line=%0d clk=%0d actual=%0d expected=%0d", tag, vm, hm, act, exp);
        end
    endtask

    task automatic compare_all();
        bit vs, hs, act;
        int cs;
        vs  = (vm >= VS0 && vm < VS0 + VSN);
        hs  = (hm < HS);
        act = (hm >= AS && hm < AS + AC && vm < LV);
        cs  = vs ? int'(hs) : int'(!hs);
        chk("R1 line_start", int'(line_start), int'(hm == 0));
        chk("R2 frame_start", int'(frame_start), int'(hm == 0 && vm == 0));
        chk("R2 line_idx", int'(line_idx), vm);
        chk("R3 pix_stb", int'(pix_stb), int'(act && ((hm - AS) % PD == 0)));
        chk("R3 pix_x", int'(pix_x), act ? (hm - AS) / PD : 0);
        chk("R4 row", int'(row), (vm < LV) ? vm / 2 : 0);
        chk(vs ? "R6 csync_n" : "R5 csync_n", int'(csync_n), cs);
        chk("R7 in_sync", int'(in_sync), 1 - cs);
        chk("R8 rgb_out", int'(rgb_out), (act && cs == 1) ? int'(rgb_in) : 0);
        chk("R10 tone_out", int'(tone_out), (hs && !vs) ? tl : 0);
    endtask

    initial begin
        // R11: reset state after edges with rst_n low
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset line_idx", int'(line_idx), 0);
        chk("R11 reset line_start", int'(line_start), 1);
        chk("R11 reset frame_start", int'(frame_start), 1);
        chk("R11 reset csync_n", int'(csync_n), 0);
        chk("R11 reset tone_out", int'(tone_out), 0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 12 * LC * LT; cyc++) begin
            @(negedge clk);
            compare_all();
            // R9: period stepping 3 -> 1 -> 0 -> 2 across frames
            if (cyc == 3 * LC * LT) tone_period = 8'd1;
            if (cyc == 6 * LC * LT) tone_period = 8'd0;
            if (cyc == 8 * LC * LT) tone_period = 8'd2;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rgb_in = lfsr[2:0];
        end
        // R11: mid-frame reset returns to the start with silence
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R11 mid reset line_idx", int'(line_idx), 0);
        chk("R11 mid reset frame_start", int'(frame_start), 1);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 2 * LC * LT; cyc++) begin
            @(negedge clk);
            compare_all();
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule